// File: doc/BRIEF.md
# Integer Line Rasterizer Stepper

This block walks a straight line between two 11-bit endpoints and produces one pixel coordinate per clock cycle. A single-cycle start pulse captures both endpoints. The block then sets its busy output and streams coordinates with a valid strobe. A last flag marks the final pixel. It uses only adders, subtractors and constant shifts; there is no multiplier or divider anywhere in the datapath.

Before stepping, the block works out which axis is the major one and normalizes the endpoints. A line whose vertical span is larger than its horizontal span is stepped along y. Endpoints are exchanged so that the major coordinate always increases. The minor coordinate moves up or down according to the direction between the normalized endpoints.

The error term is kept scaled by twice the major span. Each step adds twice the minor span to it. When the term exceeds the major span (one half, once scaled), the minor coordinate moves by one and twice the major span is taken off. A pixel-generation engine downstream uses the stream directly as write addresses.

Top module: `line_raster`

## Requirements
- R1: While rst_ni is low, and after its release until a start is accepted, busy_o and pix_valid_o are 0.
- R2: A start_i sampled high at a rising edge while busy_o is 0 is accepted. From the next cycle on, pix_valid_o is 1 for every cycle of the line, with no gaps.
- R3: A line emits exactly M+1 pixels, where M is the span of the major axis. pix_last_o is 1 on the final pixel only. After that pixel, pix_valid_o and busy_o are 0.
- R4: Let S be the minor span. For pixel k (counting from 0 after normalization), the minor coordinate is b0 + d·n, with n = floor((2·k·S + M − 1) / (2·M)). In other words, the minor coordinate moves only when the scaled error strictly exceeds the half threshold, so an exact tie keeps the current row.
- R5: Between consecutive pixels of a line, the minor coordinate changes by at most 1.
- R6: If |y1−y0| > |x1−x0|, y is the major axis, and pix_y_o is the stepped coordinate while pix_x_o is the minor one. Equal spans are treated as not steep.
- R7: Pixels are emitted starting from the endpoint with the smaller major coordinate, so the major coordinate rises by exactly 1 per pixel. This holds even when the endpoints are given in reverse order.
- R8: d is −1 when the minor coordinate of the normalized far endpoint is lower than that of the near endpoint, and +1 otherwise.
- R9: A start_i pulse while busy_o is 1 is ignored. The running line completes unchanged, and no new line follows it.
- R10: A line whose two endpoints are equal emits one pixel at that point, with pix_last_o set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| x0_i | input | 11 | First endpoint x |
| y0_i | input | 11 | First endpoint y |
| x1_i | input | 11 | Second endpoint x |
| y1_i | input | 11 | Second endpoint y |
| busy_o | output | 1 | A line is being stepped |
| pix_valid_o | output | 1 | Pixel coordinate valid this cycle |
| pix_x_o | output | 11 | Pixel x |
| pix_y_o | output | 11 | Pixel y |
| pix_last_o | output | 1 | Final pixel of the line |

## Verification
The hardest situation to reach from the ports is a start request that arrives in the middle of a running line. The stimulus raises start_i with different endpoints on the third pixel of a line. The bench then confirms that the original line finishes pixel for pixel and that valid stays low afterwards. The exact-tie rounding case is reached with the line (0,0)-(2,1). A full-range diagonal given in reverse drives the error and counter widths to their limits. Every pixel of every line is compared against a closed-form rounding formula rather than a stepped model.

// File: rtl/line_pkg.sv
package line_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } step_state_e;
endpackage

// File: rtl/line_abs_diff.sv
module line_abs_diff #(
  parameter int unsigned CW = 11
) (
  input  logic [CW-1:0] a_i,
  input  logic [CW-1:0] b_i,
  output logic [CW-1:0] mag_o,
  output logic          b_lt_a_o
);
  always_comb begin
    b_lt_a_o = b_i < a_i;
    mag_o    = b_lt_a_o ? (a_i - b_i) : (b_i - a_i);
  end
endmodule

// File: rtl/line_octant.sv
module line_octant #(
  parameter int unsigned CW = 11
) (
  input  logic [CW-1:0] x0_i,
  input  logic [CW-1:0] y0_i,
  input  logic [CW-1:0] x1_i,
  input  logic [CW-1:0] y1_i,
  output logic          steep_o,
  output logic [CW-1:0] maj_start_o,
  output logic [CW-1:0] min_start_o,
  output logic [CW-1:0] maj_span_o,
  output logic [CW-1:0] min_span_o,
  output logic          min_down_o
);
  logic [CW-1:0] span [2];
  logic          unused_lt [2];
  logic [CW-1:0] a0, a1, b0, b1;
  logic          swap;

  for (genvar g = 0; g < 2; g++) begin : g_span
    line_abs_diff #(.CW(CW)) u_diff (
      .a_i     (g == 0 ? x0_i : y0_i),
      .b_i     (g == 0 ? x1_i : y1_i),
      .mag_o   (span[g]),
      .b_lt_a_o(unused_lt[g])
    );
  end

  always_comb begin
    steep_o = span[1] > span[0];
    a0 = steep_o ? y0_i : x0_i;
    a1 = steep_o ? y1_i : x1_i;
    b0 = steep_o ? x0_i : y0_i;
    b1 = steep_o ? x1_i : y1_i;
    swap = a0 > a1;
    maj_start_o = swap ? a1 : a0;
    min_start_o = swap ? b1 : b0;
    maj_span_o  = steep_o ? span[1] : span[0];
    min_span_o  = steep_o ? span[0] : span[1];
    // far minor below near minor -> step downward
    min_down_o  = swap ? (b0 < b1) : (b1 < b0);
  end
endmodule

// File: rtl/line_step_core.sv
module line_step_core
  import line_pkg::*;
#(
  parameter int unsigned CW = 11,
  localparam int unsigned EW = CW + 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          steep_i,
  input  logic [CW-1:0] maj_start_i,
  input  logic [CW-1:0] min_start_i,
  input  logic [CW-1:0] maj_span_i,
  input  logic [CW-1:0] min_span_i,
  input  logic          min_down_i,
  output logic          busy_o,
  output logic          steep_o,
  output logic [CW-1:0] maj_o,
  output logic [CW-1:0] min_o,
  output logic          last_o
);
  step_state_e          state_q;
  logic [CW-1:0]        maj_q, min_q, remain_q, maj_span_q, min_span_q;
  logic                 steep_q, down_q;
  logic signed [EW-1:0] err_q, err_sum, thr, dec2, inc2;
  logic                 bump;

  always_comb begin
    inc2    = $signed({2'b00, min_span_q, 1'b0});
    dec2    = $signed({2'b00, maj_span_q, 1'b0});
    thr     = $signed({3'b000, maj_span_q});
    err_sum = err_q + inc2;
    bump    = err_sum > thr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      maj_q      <= '0;
      min_q      <= '0;
      remain_q   <= '0;
      maj_span_q <= '0;
      min_span_q <= '0;
      steep_q    <= 1'b0;
      down_q     <= 1'b0;
      err_q      <= '0;
    end else if (state_q == ST_IDLE) begin
      if (load_i) begin
        state_q    <= ST_RUN;
        maj_q      <= maj_start_i;
        min_q      <= min_start_i;
        remain_q   <= maj_span_i;
        maj_span_q <= maj_span_i;
        min_span_q <= min_span_i;
        steep_q    <= steep_i;
        down_q     <= min_down_i;
        err_q      <= '0;
      end
    end else if (remain_q == '0) begin
      state_q <= ST_IDLE;
    end else begin
      maj_q    <= maj_q + 1'b1;
      remain_q <= remain_q - 1'b1;
      if (bump) begin
        min_q <= down_q ? (min_q - 1'b1) : (min_q + 1'b1);
        err_q <= err_sum - dec2;
      end else begin
        err_q <= err_sum;
      end
    end
  end

  assign busy_o  = state_q == ST_RUN;
  assign steep_o = steep_q;
  assign maj_o   = maj_q;
  assign min_o   = min_q;
  assign last_o  = busy_o && (remain_q == '0);

  // R4: error stays inside the half-open window (-M, M]
  a_r4_err_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ((err_q <= thr) && ((err_q > -thr) || (maj_span_q == '0))));

  // R7: major coordinate rises by one per pixel
  a_r7_major_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last_o) |=> (busy_o && (maj_q == $past(maj_q) + 1'b1)));
endmodule

// File: rtl/line_raster.sv
module line_raster #(
  parameter int unsigned CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] x0_i,
  input  logic [CW-1:0] y0_i,
  input  logic [CW-1:0] x1_i,
  input  logic [CW-1:0] y1_i,
  output logic          busy_o,
  output logic          pix_valid_o,
  output logic [CW-1:0] pix_x_o,
  output logic [CW-1:0] pix_y_o,
  output logic          pix_last_o
);
  logic          oc_steep, oc_down, st_steep, core_busy;
  logic [CW-1:0] oc_maj, oc_min, oc_maj_span, oc_min_span, st_maj, st_min;

  line_octant #(.CW(CW)) u_octant (
    .x0_i       (x0_i),
    .y0_i       (y0_i),
    .x1_i       (x1_i),
    .y1_i       (y1_i),
    .steep_o    (oc_steep),
    .maj_start_o(oc_maj),
    .min_start_o(oc_min),
    .maj_span_o (oc_maj_span),
    .min_span_o (oc_min_span),
    .min_down_o (oc_down)
  );

  line_step_core #(.CW(CW)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_i),
    .steep_i    (oc_steep),
    .maj_start_i(oc_maj),
    .min_start_i(oc_min),
    .maj_span_i (oc_maj_span),
    .min_span_i (oc_min_span),
    .min_down_i (oc_down),
    .busy_o     (core_busy),
    .steep_o    (st_steep),
    .maj_o      (st_maj),
    .min_o      (st_min),
    .last_o     (pix_last_o)
  );

  assign busy_o      = core_busy;
  assign pix_valid_o = core_busy;
  assign pix_x_o     = st_steep ? st_min : st_maj;
  assign pix_y_o     = st_steep ? st_maj : st_min;

  // R2: no gaps inside a line
  a_r2_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_last_o) |=> pix_valid_o);

  // R3: the stream ends right after the last pixel
  a_r3_end_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && pix_last_o) |=> !pix_valid_o);

  // R5: minor coordinate moves by at most one
  a_r5_minor_unit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_last_o) |=>
      (st_steep ? ((pix_x_o - $past(pix_x_o) + 1'b1) <= CW'(2))
                : ((pix_y_o - $past(pix_y_o) + 1'b1) <= CW'(2))));

  // R9: a start while busy does not restart the line
  a_r9_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !pix_last_o && start_i) |=> (busy_o && $stable(st_steep)));

  // R1: idle after reset until a start
  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !pix_valid_o);
endmodule

// File: tb/line_raster_test.sv
module line_raster_test;
  localparam int CW = 11;
  localparam int NV = 10;
  localparam logic [4*CW-1:0] VEC [NV] = '{
    {11'd0,    11'd0,  11'd7,    11'd3},
    {11'd3,    11'd5,  11'd10,   11'd5},
    {11'd2,    11'd2,  11'd2,    11'd9},
    {11'd10,   11'd1,  11'd0,    11'd4},
    {11'd0,    11'd8,  11'd6,    11'd1},
    {11'd5,    11'd5,  11'd0,    11'd0},
    {11'd0,    11'd0,  11'd2,    11'd1},
    {11'd2047, 11'd0,  11'd0,    11'd2047},
    {11'd0,    11'd3,  11'd9,    11'd2},
    {11'd40,   11'd90, 11'd13,   11'd77}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CW-1:0] x0 = '0, y0 = '0, x1 = '0, y1 = '0;
  logic busy, pvalid, plast;
  logic [CW-1:0] px, py;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  line_raster #(.CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .x0_i(x0), .y0_i(y0), .x1_i(x1), .y1_i(y1),
    .busy_o(busy), .pix_valid_o(pvalid), .pix_x_o(px), .pix_y_o(py),
    .pix_last_o(plast)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // interfere: raise start with other endpoints on pixel 2
  task automatic run_line(input int ax0, input int ay0, input int ax1, input int ay1,
                          input bit interfere);
    int dx, dy, sp_maj, sp_min, a0, a1, b0, b1, dir, k, n, emaj, emin, ex, ey;
    bit steep;
    dx = (ax1 > ax0) ? ax1 - ax0 : ax0 - ax1;
    dy = (ay1 > ay0) ? ay1 - ay0 : ay0 - ay1;
    steep = dy > dx;                                   // R6
    a0 = steep ? ay0 : ax0; a1 = steep ? ay1 : ax1;
    b0 = steep ? ax0 : ay0; b1 = steep ? ax1 : ay1;
    if (a0 > a1) begin                                 // R7
      int t;
      t = a0; a0 = a1; a1 = t;
      t = b0; b0 = b1; b1 = t;
    end
    dir = (b1 < b0) ? -1 : 1;                          // R8
    sp_maj = a1 - a0;
    sp_min = (b1 > b0) ? b1 - b0 : b0 - b1;
    @(negedge clk);
    chk(!busy, "R2 idle before start", int'(busy), 0);
    start = 1'b1;
    x0 = CW'(ax0); y0 = CW'(ay0); x1 = CW'(ax1); y1 = CW'(ay1);
    @(negedge clk);
    start = 1'b0;
    chk(pvalid, "R2 first pixel next cycle", int'(pvalid), 1);
    k = 0;
    while (pvalid && k <= sp_maj + 2) begin
      n = (sp_maj == 0) ? 0 : (2 * k * sp_min + sp_maj - 1) / (2 * sp_maj);  // R4
      emaj = a0 + k;
      emin = b0 + dir * n;
      ex = steep ? emin : emaj;
      ey = steep ? emaj : emin;
      chk(int'(px) == ex, "R4/R6/R7/R8 x", int'(px), ex);
      chk(int'(py) == ey, "R4/R6/R7/R8 y", int'(py), ey);
      chk(plast == (k == sp_maj), "R3 last flag", int'(plast), int'(k == sp_maj));
      if (interfere && k == 2) begin
        start = 1'b1;
        x0 = 11'd500; y0 = 11'd600; x1 = 11'd900; y1 = 11'd610;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk(k == sp_maj + 1, "R3 pixel count", k, sp_maj + 1);
    chk(!busy && !pvalid, "R3 idle after last", int'(busy), 0);
    if (interfere) begin
      repeat (3) @(negedge clk);
      chk(!pvalid, "R9 no second line", int'(pvalid), 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1;
    chk(!busy && !pvalid, "R1 in reset", int'(pvalid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !pvalid, "R1 after reset", int'(pvalid), 0);

    for (int i = 0; i < NV; i++)
      run_line(int'(VEC[i][4*CW-1:3*CW]), int'(VEC[i][3*CW-1:2*CW]),
               int'(VEC[i][2*CW-1:CW]), int'(VEC[i][CW-1:0]), 1'b0);

    // R10 zero length
    run_line(1234, 17, 1234, 17, 1'b0);
    // R9 start while busy
    run_line(20, 30, 35, 25, 1'b1);
    // R6 equal spans, reversed
    run_line(9, 0, 0, 9, 1'b0);
    // R1 idle holds without start
    repeat (4) @(negedge clk);
    chk(!pvalid, "R1 idle without start", int'(pvalid), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule